// File: doc/BRIEF.md
# Infrared pulse run-length encoder

This block takes the output of an infrared receiver module that has already removed the carrier and turns it into a stream of run-length bytes. It looks at the line only on a slow sample-tick enable, for example 125 kHz, which gives 8 µs per sample. Each byte it emits carries the level of a run and that run's length in samples. The block can invert the input polarity, so receivers with either active level can be used. Short opposite-level glitches are merged into the run around them. When the line rests at the space level long enough, the block flushes the last run and signals the end of the packet.

The raw input passes through a two-flop synchronizer before it is sampled. The encoder works only while both enables are set and the mode field selects the run-length mode. A host or a protocol decoder downstream gathers the bytes and rebuilds the pulse timings. It can treat the packet-end pulse as the point at which a frame is complete.

Top module: `ir_rle_enc`

## Requirements
- R1: Each emitted byte holds the run level in bit 7 (1 = mark, 0 = space) and the run length minus one in bits 6:0, so code n stands for n+1 samples. `byte_valid` is a one-cycle strobe, and it is asserted for at most one byte per sample tick.
- R2: When `cfg_invert` is 1, a raw input of 0 is encoded as mark and a raw input of 1 as space. When it is 0, the raw level is encoded directly.
- R3: An opposite-level run counts as a real transition only once it reaches `cfg_noise_thr` samples (a threshold of 0 acts as 1). A shorter opposite run is added to the current run and produces no byte of its own.
- R4: When a run reaches 128 samples, the block emits code 0x7F at that run's level and continues counting the same level as a new run. An opposite run still pending at that moment is absorbed into the emitted byte.
- R5: When the number of consecutive space samples reaches a nonzero `cfg_idle_thr`, the block flushes the current run as a byte and pulses `pkt_end` in the same cycle. A threshold of 0 disables packet end.
- R6: After reset, after a packet end and after the encoder is re-enabled, space samples produce nothing until the first mark sample. That mark sample starts a new mark run.
- R7: The encoder runs only while `cfg_global_en` and `cfg_rx_en` are both 1 and `cfg_mode` equals 2'b11. Leaving that state drops the run in progress without emitting it.
- R8: Only cycles with `sample_en` high advance the encoder. Outputs change only in the cycle after a tick.
- R9: During and just after reset, `byte_valid`, `byte_data` and `pkt_end` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_raw | input | 1 | Demodulated receiver input, asynchronous |
| sample_en | input | 1 | Sample tick enable |
| cfg_global_en | input | 1 | Global enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_mode | input | 2 | Mode select; 2'b11 selects run-length encoding |
| cfg_invert | input | 1 | Invert input polarity |
| cfg_noise_thr | input | 6 | Minimum accepted run, in samples |
| cfg_idle_thr | input | 8 | Space samples before packet end; 0 disables |
| byte_valid | output | 1 | Output byte strobe |
| byte_data | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| pkt_end | output | 1 | Packet-end pulse |

## Verification
The bench targets the points where an off-by-one hides. An opposite run exactly at the noise threshold must commit, while one sample shorter must merge; a wrong comparison shifts every following code or splits a mark in two. A 130-sample mark must give 0xFF followed by 0x81; a wrong wrap would emit 0x00 or lose the carry-over. Idle threshold 0 must never end a packet, and an input held still with enables removed or with the wrong mode must produce nothing. A design that failed either case would emit stray space bytes or keep a stale run across the gap.

// File: rtl/ir_rle_enc.sv
module ir_rle_enc #(
  parameter int NOISE_W = 6,
  parameter int IDLE_W  = 8,
  parameter int CODE_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ir_raw,
  input  logic               sample_en,
  input  logic               cfg_global_en,
  input  logic               cfg_rx_en,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_invert,
  input  logic [NOISE_W-1:0] cfg_noise_thr,
  input  logic [IDLE_W-1:0]  cfg_idle_thr,
  output logic               byte_valid,
  output logic [CODE_W:0]    byte_data,
  output logic               pkt_end
);
  localparam int RUN_MAX = 1 << CODE_W;
  localparam int CNT_W   = CODE_W + 1;
  localparam int SPC_W   = IDLE_W + 1;
  localparam logic [1:0] MODE_RLE = 2'b11;

  logic             sync_a, sync_b;
  logic             waiting, cur_lvl;
  logic [CNT_W-1:0] cnt, cand;
  logic [SPC_W-1:0] spc;

  wire              lvl     = sync_b ^ cfg_invert;
  wire              active  = cfg_global_en & cfg_rx_en & (cfg_mode == MODE_RLE);
  wire [CNT_W-1:0]  cnt_inc = cnt + 1'b1;
  wire [CNT_W-1:0]  cand_inc = cand + 1'b1;
  wire [CNT_W-1:0]  kept    = cnt - cand;
  wire              flip    = (lvl != cur_lvl);
  wire              commit  = flip & (cand_inc >= CNT_W'(cfg_noise_thr));
  wire              sat     = (cnt_inc == CNT_W'(RUN_MAX));
  wire [SPC_W-1:0]  spc_nx  = lvl ? '0 : (&spc ? spc : spc + 1'b1);
  wire              idle    = (cfg_idle_thr != '0) && (spc_nx >= SPC_W'(cfg_idle_thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= ir_raw;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting    <= 1'b1;
      cur_lvl    <= 1'b0;
      cnt        <= '0;
      cand       <= '0;
      spc        <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      pkt_end    <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      pkt_end    <= 1'b0;
      if (!active) begin
        waiting <= 1'b1;
        cnt     <= '0;
        cand    <= '0;
        spc     <= '0;
      end else if (sample_en) begin
        if (waiting) begin
          if (lvl) begin
            waiting <= 1'b0;
            cur_lvl <= 1'b1;
            cnt     <= CNT_W'(1);
            cand    <= '0;
            spc     <= '0;
          end
        end else if (commit) begin
          if (kept != '0) begin
            byte_valid <= 1'b1;
            byte_data  <= {cur_lvl, CODE_W'(kept - 1'b1)};
          end
          cur_lvl <= lvl;
          cnt     <= cand_inc;
          cand    <= '0;
          spc     <= spc_nx;
        end else if (sat) begin
          byte_valid <= 1'b1;
          byte_data  <= {cur_lvl, {CODE_W{1'b1}}};
          cnt        <= '0;
          cand       <= '0;
          spc        <= spc_nx;
        end else if (idle) begin
          if (!cur_lvl) begin
            byte_valid <= 1'b1;
            byte_data  <= {1'b0, CODE_W'(cnt)};
          end else if (kept != '0) begin
            byte_valid <= 1'b1;
            byte_data  <= {1'b1, CODE_W'(kept - 1'b1)};
          end
          pkt_end <= 1'b1;
          waiting <= 1'b1;
          cnt     <= '0;
          cand    <= '0;
          spc     <= '0;
        end else begin
          cnt  <= cnt_inc;
          cand <= flip ? cand_inc : '0;
          spc  <= spc_nx;
        end
      end
    end
  end

  AST_VALID_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(sample_en));  // R8
  AST_PKT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> $past(sample_en));  // R8
  AST_IDLE_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> ($past(cfg_idle_thr) != '0));  // R5
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_global_en && cfg_rx_en && cfg_mode == MODE_RLE) |-> !byte_valid && !pkt_end);  // R7
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(RUN_MAX));  // R4
  AST_WAIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_end) |-> waiting || cur_lvl);  // R6
endmodule

// File: tb/ir_rle_enc_tb.sv
module ir_rle_enc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ir_raw = 1'b0, sample_en = 1'b0;
  logic g_en = 1'b1, r_en = 1'b1, inv = 1'b0;
  logic [1:0] mode = 2'b11;
  logic [5:0] nthr = 6'd1;
  logic [7:0] ithr = 8'd20;
  logic bv, pe;
  logic [7:0] bd;

  always #10 clk = ~clk;

  ir_rle_enc dut_i (.clk(clk), .rst_n(rst_n), .ir_raw(ir_raw), .sample_en(sample_en),
    .cfg_global_en(g_en), .cfg_rx_en(r_en), .cfg_mode(mode), .cfg_invert(inv),
    .cfg_noise_thr(nthr), .cfg_idle_thr(ithr), .byte_valid(bv), .byte_data(bd), .pkt_end(pe));

  int checks = 0, errors = 0, cyc = 0, pkts = 0;
  bit done = 0;
  string phase = "R9";
  logic [7:0] got_q[$];

  // behavioural reference
  bit m_s1, m_s2, m_wait = 1, m_lvl;
  int m_cnt, m_cand, m_spc;
  bit e_v, e_p;
  logic [7:0] e_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_wait = 1; m_lvl = 0; m_cnt = 0; m_cand = 0; m_spc = 0;
      e_v = 0; e_p = 0; e_d = 0;
    end else begin
      bit lv;
      int thr, spn, kept;
      lv = m_s2 ^ inv;
      e_v = 0; e_p = 0;
      if (!(g_en && r_en && mode == 2'b11)) begin
        m_wait = 1; m_cnt = 0; m_cand = 0; m_spc = 0;
      end else if (sample_en) begin
        thr = (nthr == 0) ? 1 : int'(nthr);
        spn = lv ? 0 : (m_spc < 511 ? m_spc + 1 : 511);
        kept = m_cnt - m_cand;
        if (m_wait) begin
          if (lv) begin m_wait = 0; m_lvl = 1; m_cnt = 1; m_cand = 0; m_spc = 0; end
        end else if (lv != m_lvl && m_cand + 1 >= thr) begin
          if (kept > 0) begin e_v = 1; e_d = {m_lvl, 7'(kept - 1)}; end
          m_lvl = lv; m_cnt = m_cand + 1; m_cand = 0; m_spc = spn;
        end else if (m_cnt + 1 == 128) begin
          e_v = 1; e_d = {m_lvl, 7'h7F}; m_cnt = 0; m_cand = 0; m_spc = spn;
        end else if (ithr != 0 && spn >= int'(ithr)) begin
          if (!m_lvl) begin e_v = 1; e_d = {1'b0, 7'(m_cnt)}; end
          else if (kept > 0) begin e_v = 1; e_d = {1'b1, 7'(kept - 1)}; end
          e_p = 1; m_wait = 1; m_cnt = 0; m_cand = 0; m_spc = 0;
        end else begin
          m_cand = (lv != m_lvl) ? m_cand + 1 : 0;
          m_cnt = m_cnt + 1; m_spc = spn;
        end
      end
      m_s2 = m_s1; m_s1 = ir_raw;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(bv == e_v, {phase, " valid"}, bv, e_v);
      chk(pe == e_p, {phase, " pkt_end"}, pe, e_p);
      if (e_v) chk(bd == e_d, {phase, " data"}, bd, e_d);
      if (bv) got_q.push_back(bd);
      if (pe) pkts++;
    end
    if (cyc > 150000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(bit lvl, int n);
    for (int i = 0; i < n; i++) begin
      ir_raw = lvl; sample_en = 0;
      @(negedge clk); @(negedge clk); @(negedge clk);
      sample_en = 1;
      @(negedge clk);
      sample_en = 0;
    end
  endtask

  task automatic expect_bytes(string req, logic [7:0] exp[$], int exp_pk);
    repeat (3) @(negedge clk);
    chk(got_q.size() == exp.size(), {req, " byte count"}, got_q.size(), exp.size());
    foreach (exp[i])
      if (i < got_q.size()) chk(got_q[i] == exp[i], {req, " byte"}, got_q[i], exp[i]);
    chk(pkts == exp_pk, {req, " packet count"}, pkts, exp_pk);
    got_q.delete(); pkts = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bv == 0 && pe == 0 && bd == 0, "R9 reset outputs", {bd, bv, pe}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(bv == 0 && pe == 0, "R9 after reset", {bv, pe}, 0);

    phase = "R1";  // format, R6 leading spaces ignored, R5 idle flush
    run(0, 5); run(1, 10); run(0, 6); run(1, 3); run(0, 25);
    expect_bytes("R1", '{8'h89, 8'h05, 8'h82, 8'h13}, 1);

    phase = "R3";  nthr = 3;
    run(1, 8); run(0, 2); run(1, 5); run(0, 22);
    expect_bytes("R3 merge", '{8'h8E, 8'h13}, 1);
    run(1, 4); run(0, 3); run(1, 4); run(0, 20);
    expect_bytes("R3 boundary", '{8'h83, 8'h02, 8'h83, 8'h13}, 1);
    nthr = 1;

    phase = "R4";
    run(1, 130); run(0, 20);
    expect_bytes("R4", '{8'hFF, 8'h81, 8'h13}, 1);

    phase = "R5";  ithr = 0;
    run(1, 3); run(0, 30); run(1, 2);
    ithr = 20;
    run(0, 20);
    expect_bytes("R5 idle zero", '{8'h82, 8'h1D, 8'h81, 8'h13}, 1);

    phase = "R2";  inv = 1;
    run(1, 4); run(0, 6); run(1, 20);
    expect_bytes("R2", '{8'h85, 8'h13}, 1);
    inv = 0;

    phase = "R7";  mode = 2'b01;
    run(1, 10); run(0, 25);
    expect_bytes("R7 mode", '{}, 0);
    mode = 2'b11; g_en = 0;
    run(1, 6); run(0, 22);
    expect_bytes("R7 global", '{}, 0);
    g_en = 1;
    run(1, 5); r_en = 0; run(1, 5); r_en = 1;
    run(0, 3); run(1, 4); run(0, 20);
    expect_bytes("R7 drop", '{8'h83, 8'h13}, 1);

    phase = "R8";  ir_raw = 1;
    repeat (40) @(negedge clk);
    expect_bytes("R8 no tick", '{}, 0);
    run(1, 2); run(0, 20);
    expect_bytes("R8", '{8'h81, 8'h13}, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule